// File: doc/BRIEF.md
# Range Counter with Programmable Start and End

This block is a synchronous binary up-counter, four bits wide by default, built from positive-edge flip-flops. A synchronous clear, a parallel load and a count enable control it, in that order of priority. A carry output is high while the count holds its all-ones value. Two instances can be chained into a wider counter: the low stage's carry, qualified by the low stage's enable, drives the high stage's enable.

Two mode inputs narrow the counting range.

- With the start mode set, an enabled count that would wrap from all ones reloads a programmable start value.
- With the end mode set, an enabled count sitting on a programmable end value returns to zero on the next edge.
- With both modes set, reaching the end value reloads the start value. The counter then cycles through start..end.

In every mode the carry output reflects only the all-ones state.

Top module: `range_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0 on that edge, regardless of every other input.
- R2: With `rst_n` high and `clr` high, the count becomes 0 on the next edge, overriding `ld` and `en`.
- R3: With `clr` low and `ld` high, the count takes `ld_val` on the next edge, overriding `en`; bit W-1 is the most significant bit.
- R4: With `clr`, `ld` and `en` all low, the count holds its value.
- R5: With `en` high and both mode inputs low, the count increments by one per edge and wraps from all ones to 0.
- R6: `carry` is high exactly while the count is all ones (1111 for W=4).
- R7: Two instances, the high one enabled by the low one's `carry` ANDed with the low enable, form a 2W-bit counter. The high stage increments on the edge where the low stage goes from all ones to 0.
- R8: With `start_mode` high and `end_mode` low, an enabled count at all ones loads `start_val` in place of wrapping. For `start_val`=0110 the sequence is 0110..1111, then 0110.
- R9: With `end_mode` high and `start_mode` low, an enabled count equal to `end_val` returns to 0. For `end_val`=1101 the sequence is 0000..1101, then 0000.
- R10: With both modes high, an enabled count equal to `end_val` loads `start_val` on the next edge, so the count cycles between the two values. `carry` stays low unless the count is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear to zero |
| ld | input | 1 | Synchronous parallel load of `ld_val` |
| en | input | 1 | Count enable |
| ld_val | input | W | Parallel load value, MSB at W-1 |
| start_val | input | W | Value reloaded at the bottom of the range |
| end_val | input | W | Last value of the range when end mode is on |
| start_mode | input | 1 | Reload `start_val` in place of wrapping |
| end_mode | input | 1 | Leave the range after `end_val` |
| count | output | W | Current count |
| carry | output | 1 | High while the count is all ones |

## Verification
A corrupted count register becomes visible on `count` in the cycle it happens. It also spreads within one edge, because every next value derives from the current one. A wrong carry decode appears at once on `carry`; in a chained pair, it also appears one edge later as a skipped or doubled increment in the high stage. A faulty end comparator or mode select shows as a sequence that runs one step too far or turns early. Checking the count cycle by cycle against an independent model through complete loops of each range mode therefore catches such faults within one loop.

// File: rtl/range_counter_pkg.sv
// Package: shared types for the range counter.
// Assumes: nothing beyond IEEE 1800-2017.
package range_counter_pkg;

    // Source of the next count value chosen by the control decode.
    typedef enum logic [2:0] {
        NXT_HOLD  = 3'd0,
        NXT_ZERO  = 3'd1,
        NXT_LOAD  = 3'd2,
        NXT_START = 3'd3,
        NXT_INC   = 3'd4
    } nxt_sel_t;

endpackage

// File: rtl/range_counter_detect.sv
// Module: range_counter_detect
// Decodes the all-ones state and equality of the count with the end value.
// Assumes: W >= 1; both outputs are purely combinational.
module range_counter_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] end_val,
    output logic         at_top,
    output logic         at_end
);

    logic [W-1:0] and_chain;
    logic [W-1:0] eq_bit;

    // AND chain across the count bits gives the all-ones flag.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            if (gi == 0) begin : g_first
                assign and_chain[gi] = cnt[gi];
            end else begin : g_rest
                assign and_chain[gi] = and_chain[gi-1] & cnt[gi];
            end
            assign eq_bit[gi] = ~(cnt[gi] ^ end_val[gi]);
        end
    endgenerate

    // Collapse the per-bit results into the two flags.
    always_comb begin
        at_top = and_chain[W-1];
        at_end = &eq_bit;
    end

endmodule

// File: rtl/range_counter_incr.sv
// Module: range_counter_incr
// Toggle-chain incrementer: bit i flips when all lower bits are one.
// Assumes: W >= 1; wraps from all ones to zero.
module range_counter_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cnt_inc
);

    logic [W-1:0] tgl;

    // Build the toggle enables and the XOR outputs bit by bit.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_tgl
            if (gi == 0) begin : g_lsb
                assign tgl[gi] = 1'b1;
            end else begin : g_upper
                assign tgl[gi] = tgl[gi-1] & cnt[gi-1];
            end
            assign cnt_inc[gi] = cnt[gi] ^ tgl[gi];
        end
    endgenerate

endmodule

// File: rtl/range_counter_ctrl.sv
// Module: range_counter_ctrl
// Chooses the next-value source: clear, then load, then enable; when
// enabled, end match wins over the all-ones reload.
// Assumes: reset is handled in the state register, not here.
module range_counter_ctrl
    import range_counter_pkg::*;
(
    input  logic     clr,
    input  logic     ld,
    input  logic     en,
    input  logic     start_mode,
    input  logic     end_mode,
    input  logic     at_top,
    input  logic     at_end,
    output nxt_sel_t sel
);

    // Priority decode of the next-value source.
    always_comb begin
        if (clr) begin
            sel = NXT_ZERO;
        end else if (ld) begin
            sel = NXT_LOAD;
        end else if (!en) begin
            sel = NXT_HOLD;
        end else if (end_mode && at_end) begin
            sel = start_mode ? NXT_START : NXT_ZERO;
        end else if (start_mode && at_top) begin
            sel = NXT_START;
        end else begin
            sel = NXT_INC;
        end
    end

endmodule

// File: rtl/range_counter_state.sv
// Module: range_counter_state
// Count register with a synchronous active-low reset and a select mux.
// Assumes: sel is settled before the rising edge.
module range_counter_state
    import range_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  nxt_sel_t     sel,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] start_val,
    input  logic [W-1:0] cnt_inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] ZERO = '0;

    // Register update: reset first, then the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ZERO;
        end else begin
            case (sel)
                NXT_ZERO:  cnt <= ZERO;
                NXT_LOAD:  cnt <= ld_val;
                NXT_START: cnt <= start_val;
                NXT_INC:   cnt <= cnt_inc;
                default:   cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/range_counter.sv
// Module: range_counter
// Synchronous up-counter with clear, load, enable, carry for chaining,
// and optional start/end offsets that bound the counting range.
// Assumes: all control inputs are synchronous to clk.
module range_counter
    import range_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         en,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] start_val,
    input  logic [W-1:0] end_val,
    input  logic         start_mode,
    input  logic         end_mode,
    output logic [W-1:0] count,
    output logic         carry
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;
    logic         at_top;
    logic         at_end;
    nxt_sel_t     sel;

    range_counter_detect #(.W(W)) u_detect (
        .cnt     (cnt_q),
        .end_val (end_val),
        .at_top  (at_top),
        .at_end  (at_end)
    );

    range_counter_incr #(.W(W)) u_incr (
        .cnt     (cnt_q),
        .cnt_inc (cnt_inc)
    );

    range_counter_ctrl u_ctrl (
        .clr        (clr),
        .ld         (ld),
        .en         (en),
        .start_mode (start_mode),
        .end_mode   (end_mode),
        .at_top     (at_top),
        .at_end     (at_end),
        .sel        (sel)
    );

    range_counter_state #(.W(W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .ld_val    (ld_val),
        .start_val (start_val),
        .cnt_inc   (cnt_inc),
        .cnt       (cnt_q)
    );

    // Drive the ports from the register and the top-state decode.
    always_comb begin
        count = cnt_q;
        carry = at_top;
    end

endmodule

// File: rtl/range_counter_checker.sv
// Module: range_counter_checker
// Temporal checks on the range counter ports, attached by bind.
// Assumes: it sees the same clock and reset as the counter.
module range_counter_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         ld,
    input logic         en,
    input logic [W-1:0] ld_val,
    input logic [W-1:0] start_val,
    input logic [W-1:0] end_val,
    input logic         start_mode,
    input logic         end_mode,
    input logic [W-1:0] count,
    input logic         carry
);

    // R2: a clear empties the count on the next edge
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R3: a load takes the load value on the next edge
    p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (count == $past(ld_val)));

    // R4: with no control active the count holds
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !en) |=> $stable(count));

    // R5: plain mode wraps from the carry state to zero
    p_wrap_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && !start_mode && !end_mode && carry) |=> (count == '0));

    // R8: start mode reloads the start value from the carry state
    p_start_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && start_mode && !end_mode && carry)
        |=> (count == $past(start_val)));

    // R9: end mode returns to zero after the end value
    p_end_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && end_mode && !start_mode && count == end_val)
        |=> (count == '0));

    // R10: combined mode turns from the end value to the start value
    p_range_turn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && end_mode && start_mode && count == end_val)
        |=> (count == $past(start_val)));

endmodule

bind range_counter range_counter_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .ld         (ld),
    .en         (en),
    .ld_val     (ld_val),
    .start_val  (start_val),
    .end_val    (end_val),
    .start_mode (start_mode),
    .end_mode   (end_mode),
    .count      (count),
    .carry      (carry)
);

// File: tb/range_counter_test.sv
`timescale 1ns/1ps
module range_counter_test;

    localparam int W = 4;
    localparam int NVEC = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         ld = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] ld_val = '0;
    logic [W-1:0] start_val = '0;
    logic [W-1:0] end_val = '0;
    logic         start_mode = 1'b0;
    logic         end_mode = 1'b0;
    logic [W-1:0] count;
    logic         carry;
    logic [W-1:0] count_hi;
    logic         carry_hi;
    logic         en_hi;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign en_hi = carry & en;

    range_counter #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .en(en),
        .ld_val(ld_val), .start_val(start_val), .end_val(end_val),
        .start_mode(start_mode), .end_mode(end_mode),
        .count(count), .carry(carry)
    );

    // High stage of the chained pair for R7.
    range_counter #(.W(W)) uut_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(1'b0), .en(en_hi),
        .ld_val('0), .start_val('0), .end_val('0),
        .start_mode(1'b0), .end_mode(1'b0),
        .count(count_hi), .carry(carry_hi)
    );

    // Vector layout: clr ld en smode emode | ld_val | start | end | exp count | exp carry
    localparam logic [21:0] VEC [NVEC] = '{
        22'b01000_1110_0000_0000_1110_0, // R3 load 1110
        22'b00100_0000_0000_0000_1111_1, // R5/R6 count to 1111, carry high
        22'b00100_0000_0000_0000_0000_0, // R5 wrap to 0000
        22'b00000_0000_0000_0000_0000_0, // R4 hold
        22'b01100_0101_0000_0000_0101_0, // R3 load beats enable
        22'b00000_0000_0000_0000_0101_0, // R4 hold
        22'b11100_1010_0000_0000_0000_0, // R2 clear beats load and enable
        22'b00100_0000_0000_0000_0001_0, // R5 increment
        22'b01000_1111_0000_0000_1111_1, // R3 load 1111
        22'b00110_0000_0110_0000_0110_0, // R8 reload start 0110
        22'b00110_0000_0110_0000_0111_0, // R8 continue counting
        22'b00101_0000_0000_1000_1000_0, // R9 count onto end value
        22'b00101_0000_0000_1000_0000_0, // R9 end value returns to 0
        22'b01111_1100_0011_1100_1100_0, // R3 load 1100 in combined mode
        22'b00111_0000_0011_1100_0011_0, // R10 end value loads start 0011
        22'b00011_0000_0011_1100_0011_0  // R4 hold in combined mode
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] c, input logic sm,
                                               input logic em, input logic [W-1:0] sv,
                                               input logic [W-1:0] ev);
        if (em && c == ev) return sm ? sv : '0;
        if (sm && c == {W{1'b1}}) return sv;
        return c + 1'b1;
    endfunction

    // Run a mode for n edges from the current count, comparing each step.
    task automatic run_mode(input string req, input logic sm, input logic em,
                            input logic [W-1:0] sv, input logic [W-1:0] ev, input int n);
        logic [W-1:0] m;
        m = count;
        start_mode = sm; end_mode = em; start_val = sv; end_val = ev;
        en = 1'b1; ld = 1'b0; clr = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            m = ref_next(m, sm, em, sv, ev);
            check(req, count, m);
            check("R6", carry, (m == {W{1'b1}}));
        end
        en = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset with load and enable active still yields zero
        rst_n = 1'b0; ld = 1'b1; en = 1'b1; ld_val = 4'b1010;
        repeat (2) @(negedge clk);
        check("R1", count, 0);
        check("R6", carry, 0);
        ld = 1'b0; en = 1'b0;
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            {clr, ld, en, start_mode, end_mode, ld_val, start_val, end_val} = VEC[v][21:5];
            @(negedge clk);
            check($sformatf("vec%0d", v), count, VEC[v][4:1]);
            check("R6", carry, VEC[v][0]);
        end
        clr = 1'b0; ld = 1'b0; en = 1'b0; start_mode = 1'b0; end_mode = 1'b0;

        // R5: plain counting over more than one wrap
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        run_mode("R5", 1'b0, 1'b0, 4'h0, 4'h0, 20);

        // R8: start-only range 0110..1111
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        run_mode("R8", 1'b1, 1'b0, 4'b0110, 4'h0, 30);

        // R9: end-only range 0000..1101
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        run_mode("R9", 1'b0, 1'b1, 4'h0, 4'b1101, 30);

        // R10: combined range 0011..1001, carry never high
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        run_mode("R10", 1'b1, 1'b1, 4'b0011, 4'b1001, 30);

        // R7: chained pair counts 256 steps and returns to zero
        start_mode = 1'b0; end_mode = 1'b0;
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        check("R7", {count_hi, count}, 0);
        en = 1'b1;
        for (int i = 1; i <= 256; i++) begin
            @(negedge clk);
            check("R7", {count_hi, count}, i % 256);
        end
        en = 1'b0;

        // R1: reset in mid-run clears a nonzero count
        ld = 1'b1; ld_val = 4'b0111; @(negedge clk); ld = 1'b0;
        rst_n = 1'b0; en = 1'b1; @(negedge clk);
        check("R1", count, 0);
        rst_n = 1'b1; en = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule